// File: doc/BRIEF.md
# Byte Receiver for a Two-Wire Serial Bus (Target Side, with Clock Hold)

This block is the receiving end of a two-wire serial bus (I2C, 7-bit addressing, write direction only). It watches the clock and data lines for a start condition and shifts in the first byte. If the upper seven bits equal the programmed own address and the direction bit is 0, it answers with an acknowledge. Every data byte that follows is shifted in and passed to a single host-visible data register. A host agent sees five status flags and clears them through one-cycle strobes that stand for reads and writes of status and control registers.

The data register and the shift register together hold up to two bytes. If a byte completes while the previous one has not yet been collected, the block raises a stall flag and holds the clock line low once the bus initiator has driven it low. The transfer stays frozen until the host reads the data register. That read moves the waiting byte into the data register and lets the clock go on the next cycle. Both bus lines are outputs that can only pull low, as on an open-drain bus. Each line passes through a two-flop synchroniser and a two-sample agreement filter before any edge is decoded.

Top module: `i2cs_receiver`

## Requirements
- R1: After reset all five flags are 0, `data_o` is 0 and neither line is pulled low.
- R2: A first byte whose bits [7:1] equal `own_addr_i` and whose bit 0 is 0 is acknowledged: SDA is pulled low during the 9th clock, only while SCL is low at the change, and `flag_match_o` is set. Any other first byte, including one with bit 0 = 1, gets no acknowledge and sets no flag, and the block ignores the bus until the next start.
- R3: `flag_match_o` is cleared only by a `st1_rd_i` strobe followed by a `st2_rd_i` strobe. A `st2_rd_i` strobe without a preceding `st1_rd_i` strobe leaves it set.
- R4: When the data register is empty, a received data byte (MSB first) is loaded into `data_o` and sets `flag_full_o`. A `dat_rd_i` strobe clears `flag_full_o`.
- R5: A data byte is acknowledged if `ack_en_i` is 1, and is not acknowledged if `ack_en_i` is 0.
- R6: If `flag_full_o` is still set when the next data byte completes, `flag_stall_o` is set and `data_o` keeps the earlier byte. `scl_pull_o` then holds SCL low from the first moment SCL is seen low.
- R7: A `dat_rd_i` strobe during a stall loads the waiting byte into `data_o`, leaves `flag_full_o` set and clears `flag_stall_o`. `scl_pull_o` goes low in the cycle after the strobe.
- R8: `flag_busy_o` is set by a start condition (SDA falling while SCL is high) and cleared by a stop condition (SDA rising while SCL is high).
- R9: A stop that ends a transfer in which the block was addressed sets `flag_stop_o`. It is cleared only by a `st1_rd_i` strobe followed by a `ctl_wr_i` strobe. A `ctl_wr_i` strobe alone leaves it set.
- R10: A start that arrives before a stop (a repeated start) begins a new address phase, whatever state the previous transfer was in.
- R11: A low pulse on SDA that lasts a single clock cycle while SCL is high is rejected by the line filter and is not seen as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| own_addr_i | input | 7 | Own address that the block answers to |
| ack_en_i | input | 1 | Acknowledge data bytes when 1 |
| st1_rd_i | input | 1 | Strobe: status register 1 read |
| st2_rd_i | input | 1 | Strobe: status register 2 read |
| dat_rd_i | input | 1 | Strobe: data register read |
| ctl_wr_i | input | 1 | Strobe: control register 1 write |
| scl_pull_o | output | 1 | Pull the clock line low (stretch) |
| sda_pull_o | output | 1 | Pull the data line low (acknowledge) |
| data_o | output | 8 | Data register contents |
| flag_match_o | output | 1 | Own address matched |
| flag_full_o | output | 1 | Data register holds an unread byte |
| flag_stall_o | output | 1 | Second byte waiting, clock held low |
| flag_stop_o | output | 1 | Stop seen after being addressed |
| flag_busy_o | output | 1 | Bus between start and stop |

## Verification
The assertions check the following on every cycle:
- The acknowledge pull only ever begins while SCL is low.
- A stall never exists without a full data register.
- SCL is let go one cycle after a data read during a stall.
- A start always raises busy.
- A strobe given out of its clear sequence leaves the match and stop flags set.
- A data read with no stall and no new byte empties the register.

Only the bench scenarios can show the bus-level results. These are which address and direction bytes get an acknowledge, the byte order in the data register across a stall, the effect of repeated starts, and the rejection of a one-cycle SDA glitch.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK_SET,
    ST_ACK_HOLD,
    ST_SKIP
  } eng_state_t;

  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
  localparam int unsigned N_LINES  = 2;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic lvl,
  output logic rose,
  output logic fell
);
  localparam int unsigned SH_W = SYNC_LEN + 1;

  logic [SH_W-1:0] sh;
  logic            agree;

  assign agree = (sh[SH_W-1] == sh[SH_W-2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      lvl  <= 1'b1;
      rose <= 1'b0;
      fell <= 1'b0;
    end else begin
      sh   <= {sh[SH_W-2:0], raw};
      rose <= agree &&  sh[SH_W-1] && !lvl;
      fell <= agree && !sh[SH_W-1] &&  lvl;
      if (agree) lvl <= sh[SH_W-1];
    end
  end
endmodule

// File: rtl/i2cs_rx_engine.sv
module i2cs_rx_engine #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_rose,
  input  logic              scl_fell,
  input  logic              sda_lvl,
  input  logic              sda_rose,
  input  logic              sda_fell,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic              ack_en,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ev_start,
  output logic              ev_stop,
  output logic              ev_stop_sel,
  output logic              ev_addr_hit,
  output logic              ev_data
);
  import i2cs_pkg::*;

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              is_addr;
  logic              sel;
  logic              ack_q;
  logic [BYTE_W-1:0] nxt;

  assign nxt = {rx_byte[BYTE_W-2:0], sda_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      is_addr     <= 1'b0;
      sel         <= 1'b0;
      ack_q       <= 1'b0;
      sda_pull    <= 1'b0;
      rx_byte     <= '0;
      ev_start    <= 1'b0;
      ev_stop     <= 1'b0;
      ev_stop_sel <= 1'b0;
      ev_addr_hit <= 1'b0;
      ev_data     <= 1'b0;
    end else begin
      ev_start    <= 1'b0;
      ev_stop     <= 1'b0;
      ev_stop_sel <= 1'b0;
      ev_addr_hit <= 1'b0;
      ev_data     <= 1'b0;
      if (sda_fell && scl_lvl) begin
        state    <= ST_SHIFT;
        cnt      <= '0;
        is_addr  <= 1'b1;
        sel      <= 1'b0;
        sda_pull <= 1'b0;
        ev_start <= 1'b1;
      end else if (sda_rose && scl_lvl) begin
        state       <= ST_IDLE;
        sel         <= 1'b0;
        sda_pull    <= 1'b0;
        ev_stop     <= 1'b1;
        ev_stop_sel <= sel;
      end else begin
        case (state)
          ST_SHIFT: if (scl_rose) begin
            rx_byte <= nxt;
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              if (is_addr) begin
                if (nxt[BYTE_W-1:1] == own_addr && !nxt[0]) begin
                  ev_addr_hit <= 1'b1;
                  sel         <= 1'b1;
                  ack_q       <= 1'b1;
                  state       <= ST_ACK_SET;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                ev_data <= 1'b1;
                ack_q   <= ack_en;
                state   <= ST_ACK_SET;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ACK_SET: if (scl_fell) begin
            sda_pull <= ack_q;
            state    <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fell) begin
            sda_pull <= 1'b0;
            is_addr  <= 1'b0;
            state    <= ST_SHIFT;
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the acknowledge pull may only start while the clock line is low
  a_r2_ack_starts_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_pull && !$past(sda_pull)) |-> !scl_lvl);

  // R10: any start restarts the address phase
  a_r10_start_restarts: assert property (@(posedge clk) disable iff (rst)
    ev_start |-> (state == ST_SHIFT && is_addr && cnt == '0));
endmodule

// File: rtl/i2cs_host_regs.sv
module i2cs_host_regs #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_stop_sel,
  input  logic              ev_addr_hit,
  input  logic              ev_data,
  input  logic              rd_sr1,
  input  logic              rd_sr2,
  input  logic              rd_dr,
  input  logic              wr_cr1,
  output logic [BYTE_W-1:0] dat_q,
  output logic              f_addr,
  output logic              f_full,
  output logic              f_stall,
  output logic              f_stop,
  output logic              f_busy,
  output logic              scl_pull
);
  logic              armed;
  logic              full_n;
  logic              stall_n;
  logic [BYTE_W-1:0] dat_n;

  always_comb begin
    full_n  = f_full;
    stall_n = f_stall;
    dat_n   = dat_q;
    if (rd_dr) begin
      if (f_stall) begin
        dat_n   = rx_byte;
        stall_n = 1'b0;
      end else begin
        full_n = 1'b0;
      end
    end
    if (ev_data) begin
      if (full_n) begin
        stall_n = 1'b1;
      end else begin
        dat_n  = rx_byte;
        full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      dat_q    <= '0;
      f_addr   <= 1'b0;
      f_full   <= 1'b0;
      f_stall  <= 1'b0;
      f_stop   <= 1'b0;
      f_busy   <= 1'b0;
      scl_pull <= 1'b0;
    end else begin
      dat_q    <= dat_n;
      f_full   <= full_n;
      f_stall  <= stall_n;
      scl_pull <= stall_n && !scl_lvl;

      if (rd_sr1) armed <= 1'b1;
      else if (rd_sr2 || wr_cr1 || rd_dr) armed <= 1'b0;

      if (ev_addr_hit) f_addr <= 1'b1;
      else if (rd_sr2 && armed) f_addr <= 1'b0;

      if (ev_stop_sel) f_stop <= 1'b1;
      else if (wr_cr1 && armed) f_stop <= 1'b0;

      if (ev_start) f_busy <= 1'b1;
      else if (ev_stop) f_busy <= 1'b0;
    end
  end

  a_r7_release_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (f_stall && rd_dr) |=> !scl_pull);

  a_r6_stall_needs_full: assert property (@(posedge clk) disable iff (rst)
    f_stall |-> f_full);

  a_r3_match_needs_sequence: assert property (@(posedge clk) disable iff (rst)
    (f_addr && rd_sr2 && !armed && !ev_addr_hit) |=> f_addr);

  a_r9_stop_needs_sequence: assert property (@(posedge clk) disable iff (rst)
    (f_stop && wr_cr1 && !armed) |=> f_stop);

  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> f_busy);

  a_r4_read_empties: assert property (@(posedge clk) disable iff (rst)
    (rd_dr && f_full && !f_stall && !ev_data) |=> !f_full);
endmodule

// File: rtl/i2cs_receiver.sv
module i2cs_receiver #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [BYTE_W-2:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic              st1_rd_i,
  input  logic              st2_rd_i,
  input  logic              dat_rd_i,
  input  logic              ctl_wr_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              flag_match_o,
  output logic              flag_full_o,
  output logic              flag_stall_o,
  output logic              flag_stop_o,
  output logic              flag_busy_o
);
  import i2cs_pkg::*;

  logic [N_LINES-1:0] raw_v, lvl_v, rose_v, fell_v;
  logic [BYTE_W-1:0]  rx_byte;
  logic ev_start, ev_stop, ev_stop_sel, ev_addr_hit, ev_data;

  assign raw_v[LINE_SCL] = scl_i;
  assign raw_v[LINE_SDA] = sda_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2cs_line_filter #(.SYNC_LEN(SYNC_LEN)) u_filt (
      .clk (clk),
      .rst (rst),
      .raw (raw_v[g]),
      .lvl (lvl_v[g]),
      .rose(rose_v[g]),
      .fell(fell_v[g])
    );
  end

  i2cs_rx_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .scl_lvl    (lvl_v[LINE_SCL]),
    .scl_rose   (rose_v[LINE_SCL]),
    .scl_fell   (fell_v[LINE_SCL]),
    .sda_lvl    (lvl_v[LINE_SDA]),
    .sda_rose   (rose_v[LINE_SDA]),
    .sda_fell   (fell_v[LINE_SDA]),
    .own_addr   (own_addr_i),
    .ack_en     (ack_en_i),
    .sda_pull   (sda_pull_o),
    .rx_byte    (rx_byte),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_stop_sel(ev_stop_sel),
    .ev_addr_hit(ev_addr_hit),
    .ev_data    (ev_data)
  );

  i2cs_host_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .scl_lvl    (lvl_v[LINE_SCL]),
    .rx_byte    (rx_byte),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_stop_sel(ev_stop_sel),
    .ev_addr_hit(ev_addr_hit),
    .ev_data    (ev_data),
    .rd_sr1     (st1_rd_i),
    .rd_sr2     (st2_rd_i),
    .rd_dr      (dat_rd_i),
    .wr_cr1     (ctl_wr_i),
    .dat_q      (data_o),
    .f_addr     (flag_match_o),
    .f_full     (flag_full_o),
    .f_stall    (flag_stall_o),
    .f_stop     (flag_stop_o),
    .f_busy     (flag_busy_o),
    .scl_pull   (scl_pull_o)
  );

  a_r6_no_clock_hold_without_stall: assert property (@(posedge clk) disable iff (rst)
    scl_pull_o |-> flag_stall_o);
endmodule

// File: tb/i2cs_receiver_bench.sv
module i2cs_receiver_bench;
  localparam int HP = 16;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic ack_en = 1'b1;
  logic st1 = 0, st2 = 0, drd = 0, cwr = 0;
  logic scl_pull, sda_pull;
  logic [7:0] data;
  logic f_match, f_full, f_stall, f_stop, f_busy;
  logic scl_line, sda_line;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign scl_line = m_scl & ~scl_pull;
  assign sda_line = m_sda & ~sda_pull;

  i2cs_receiver u_i2cs_receiver (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .own_addr_i(OWN), .ack_en_i(ack_en),
    .st1_rd_i(st1), .st2_rd_i(st2), .dat_rd_i(drd), .ctl_wr_i(cwr),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .data_o(data),
    .flag_match_o(f_match), .flag_full_o(f_full), .flag_stall_o(f_stall),
    .flag_stop_o(f_stop), .flag_busy_o(f_busy)
  );

  // entry: {addr[6:0], rw, data[7:0], ack_en, expect_hit}
  localparam logic [17:0] TBL [5] = '{
    {7'h3A, 1'b0, 8'hA5, 1'b1, 1'b1},
    {7'h3A, 1'b0, 8'h5C, 1'b0, 1'b1},
    {7'h21, 1'b0, 8'h77, 1'b1, 1'b0},
    {7'h3A, 1'b1, 8'h10, 1'b1, 1'b0},
    {7'h3B, 1'b0, 8'hFF, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      1: st1 = 1'b1;
      2: st2 = 1'b1;
      3: drd = 1'b1;
      default: cwr = 1'b1;
    endcase
    @(negedge clk);
    st1 = 0; st2 = 0; drd = 0; cwr = 0;
    waitc(2);
  endtask

  task automatic m_start;
    m_sda = 1'b1; waitc(HP);
    m_scl = 1'b1; waitc(HP);
    m_sda = 1'b0; waitc(HP);
    m_scl = 1'b0; waitc(HP);
  endtask

  task automatic m_stop;
    m_sda = 1'b0; waitc(HP);
    m_scl = 1'b1; waitc(HP);
    m_sda = 1'b1; waitc(HP);
  endtask

  task automatic m_bit(input logic b, output logic s);
    m_sda = b; waitc(HP);
    m_scl = 1'b1;
    wait (scl_line);
    waitc(HP / 2);
    s = sda_line;
    waitc(HP / 2);
    m_scl = 1'b0; waitc(4);
  endtask

  task automatic m_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(v[i], s);
    m_bit(1'b1, s);
    ack = ~s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic a1, a2;
    waitc(5);
    rst = 1'b0;
    waitc(3);
    // R1 reset state
    chk("R1 flags", {f_match, f_full, f_stall, f_stop, f_busy}, 0);
    chk("R1 data", data, 0);
    chk("R1 pulls", {scl_pull, sda_pull}, 0);

    for (int k = 0; k < 5; k++) begin
      logic [17:0] e;
      e = TBL[k];
      ack_en = e[1];
      m_start;
      chk("R8 busy after start", f_busy, 1);
      m_byte(e[17:10], a1);
      chk("R2 address ack", a1, e[0]);
      chk("R2 match flag", f_match, e[0]);
      if (e[0]) begin
        strobe(1); strobe(2);
        chk("R3 match cleared by sequence", f_match, 0);
      end
      m_byte(e[9:2], a2);
      chk("R5 data ack", a2, e[0] & e[1]);
      chk("R4 full flag", f_full, e[0]);
      if (e[0]) chk("R4 data value", data, e[9:2]);
      m_stop;
      chk("R8 busy after stop", f_busy, 0);
      chk("R9 stop flag", f_stop, e[0]);
      if (e[0]) begin
        strobe(1); strobe(4);
        chk("R9 stop cleared by sequence", f_stop, 0);
        strobe(3);
        chk("R4 read empties", f_full, 0);
      end
    end

    // R11 one-cycle glitch on SDA while SCL high
    @(negedge clk); m_sda = 1'b0;
    @(negedge clk); m_sda = 1'b1;
    waitc(10);
    chk("R11 glitch rejected", f_busy, 0);

    // R10 repeated start after a missed address, R3/R9 out-of-order strobes
    ack_en = 1'b1;
    m_start;
    m_byte({7'h3B, 1'b0}, a1);
    chk("R10 first address missed", a1, 0);
    m_start;
    m_byte({OWN, 1'b0}, a1);
    chk("R10 repeated start address ack", a1, 1);
    strobe(2);
    chk("R3 lone st2 keeps match", f_match, 1);
    strobe(1); strobe(2);
    chk("R3 sequence clears match", f_match, 0);

    // R6/R7 stall: two bytes without reading
    m_byte(8'h96, a1);
    chk("R4 first byte", data, 8'h96);
    fork
      m_byte(8'hC3, a2);
      begin
        wait (f_stall);
        wait (scl_pull);
        waitc(40);
        chk("R6 clock held", scl_pull, 1);
        chk("R6 line held low", scl_line, 0);
        chk("R6 data keeps first", data, 8'h96);
        @(negedge clk); drd = 1'b1;
        @(negedge clk); drd = 1'b0;
        chk("R7 clock released next cycle", scl_pull, 0);
        chk("R7 second byte loaded", data, 8'hC3);
        chk("R7 full stays", f_full, 1);
        chk("R7 stall cleared", f_stall, 0);
      end
    join
    chk("R5 stalled byte acked", a2, 1);
    strobe(3);
    chk("R4 empty after read", f_full, 0);
    m_stop;
    chk("R9 stop flag set", f_stop, 1);
    strobe(4);
    chk("R9 lone write keeps stop", f_stop, 1);
    strobe(1); strobe(4);
    chk("R9 sequence clears stop", f_stop, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule